// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Registered Read Port

This block buffers bytes between two clock domains that may run at unrelated frequencies or share one clock. A producer presents a byte together with an active-low write strobe on the write clock; a consumer pulls bytes into an output register with an active-low read strobe on the read clock. Two active-low status outputs tell each side whether it may proceed. The "not full" flag belongs to the write domain and the "not empty" flag belongs to the read domain. A strobe that arrives while its own flag forbids the transfer is dropped without any effect.

Each side keeps a binary pointer that is one bit wider than the address. The pointer is also kept in Gray code and passed to the other domain through a two-stage synchronizer. Each flag is a comparison between a local register and a synchronized copy, so it only changes after an edge of its own clock. A flag can report the FIFO as full or empty for a short time after this is no longer true. It never reports free space or data that does not exist. An output-enable input gates the data bus: when it is deasserted, the bus is forced to zero and a separate drive-valid bit goes low. Building a two-channel part only needs two instances side by side.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is low, and after it rises with no traffic, empty_n is 0, full_n is 1 and the output register holds 8'h00.
- R2: A byte on din is stored on a rising wclk edge only when wen_n is 0 and full_n is 1. With wen_n at 1 nothing is stored, whatever din carries.
- R3: With no reads since reset, full_n falls right after the edge that stores the DEPTH-th byte. Further write strobes while full_n is 0 store nothing and do not disturb the stored bytes.
- R4: On a rising rclk edge with ren_n at 0 and empty_n at 1, the oldest byte moves into the output register. While empty_n is 0 the strobe is ignored and the register holds its value.
- R5: While ren_n is 1, the output register keeps its value across rclk edges.
- R6: empty_n falls right after the read edge that removes the last byte. With one shared clock, a byte written into an empty FIFO at edge n makes empty_n rise after edge n+2 and not earlier.
- R7: With one shared clock, a read at edge m on a full FIFO makes full_n rise after edge m+2 and not earlier.
- R8: Bytes leave in exactly the order they entered, under unrelated clock frequencies and irregular strobes, with no loss or duplication.
- R9: While oe_n is 1, dout is 8'h00 and dout_vld is 0. While oe_n is 0, dout shows the output register and dout_vld is 1.
- R10: With one shared clock and a FIFO holding a mid-range count, a write and a read on the same edge both take effect: the count is unchanged and neither flag moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wen_n | input | 1 | Write strobe, active low |
| din | input | DW | Byte to store |
| rclk | input | 1 | Read-side clock |
| ren_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| rst_n | input | 1 | Asynchronous reset for both sides, active low |
| dout | output | DW | Gated contents of the output register |
| dout_vld | output | 1 | High when dout is being driven |
| empty_n | output | 1 | Low when the read side sees no data (read domain) |
| full_n | output | 1 | Low when the write side sees no space (write domain) |

## Verification
The hardest cases to reach from the ports are the two boundary latencies and the same-edge read and write. Their outcome depends on where the synchronized pointer copies lag the real ones. The bench runs these cases with one shared clock, so every edge count is exact. It fills a small instance until full_n falls, and it times the recovery of each flag edge by edge. It runs the overlapped read and write only at a mid-range count, where the lag cannot raise a flag. A second phase uses unrelated clock periods and irregular strobes against a queue model. First the writer is faster, so the FIFO hits its full boundary again and again. Then the reader is faster, so the FIFO keeps hitting empty.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int PTR_MAX_W = 32;

    function automatic logic [PTR_MAX_W-1:0] to_gray(input logic [PTR_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX_W-1:0] from_gray(input logic [PTR_MAX_W-1:0] g);
        logic [PTR_MAX_W-1:0] b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [AW:0]   rgray_s,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } wst_t;

    wst_t st_d, st_q;
    logic full;

    always_comb begin
        full    = (st_q.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        wr_fire = ~wen_n & ~full;
        st_d    = st_q;
        if (wr_fire) begin
            st_d.bin  = st_q.bin + (AW+1)'(1);
            st_d.gray = (AW+1)'(to_gray(PTR_MAX_W'(st_d.bin)));
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr  = st_q.bin[AW-1:0];
    assign wgray  = st_q.gray;
    assign full_n = ~full;

    logic [AW:0] rbin_s;
    assign rbin_s = (AW+1)'(from_gray(PTR_MAX_W'(rgray_s)));

    // R3
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q.bin - rbin_s) <= CAP);

    // R2
    wptr_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wen_n |=> $stable(st_q.bin));

    // R8
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic [DW-1:0] dreg
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t st_d, st_q;
    logic empty;
    logic rd_fire;

    always_comb begin
        empty   = (st_q.gray == wgray_s);
        rd_fire = ~ren_n & ~empty;
        st_d    = st_q;
        if (rd_fire) begin
            st_d.bin  = st_q.bin + (AW+1)'(1);
            st_d.gray = (AW+1)'(to_gray(PTR_MAX_W'(st_d.bin)));
            st_d.dout = mem_rdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr   = st_q.bin[AW-1:0];
    assign rgray   = st_q.gray;
    assign empty_n = ~empty;
    assign dreg    = st_q.dout;

    logic [AW:0] wbin_s;
    assign wbin_s = (AW+1)'(from_gray(PTR_MAX_W'(wgray_s)));

    // R4
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (wbin_s - st_q.bin) <= CAP);

    // R5
    dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        ren_n |=> $stable(st_q.dout));

    // R4
    empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |=> $stable(st_q.bin));

    // R8
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic          wclk,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          rclk,
    input  logic          ren_n,
    input  logic          oe_n,
    input  logic          rst_n,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          empty_n,
    output logic          full_n
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          wr_fire;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] dreg;

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .rgray_s(rgray_s),
        .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray), .full_n(full_n)
    );

    dcf_sync #(.W(AW+1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_sync #(.W(AW+1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wgray_s(wgray_s),
        .mem_rdata(mem[raddr]), .raddr(raddr), .rgray(rgray),
        .empty_n(empty_n), .dreg(dreg)
    );

    always_ff @(posedge wclk) begin
        if (wr_fire) mem[waddr] <= din;
    end

    assign dout     = oe_n ? '0 : dreg;
    assign dout_vld = ~oe_n;
endmodule

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH = 16;
    localparam int NWORDS = 200;

    logic wclk = 1'b0, rclk_free = 1'b0, shared = 1'b1;
    logic rclk;
    logic wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0, rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic dout_vld, empty_n, full_n;

    int vecs = 0, errs = 0;
    bit full_seen = 0;
    byte unsigned q[$];

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk_free = ~rclk_free;
    assign rclk = shared ? wclk : rclk_free;

    dcf_fifo #(.DW(8), .DEPTH(DEPTH)) u_dut (
        .wclk(wclk), .wen_n(wen_n), .din(din), .rclk(rclk), .ren_n(ren_n),
        .oe_n(oe_n), .rst_n(rst_n), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge wclk);
        @(negedge wclk);
    endtask

    function automatic logic [7:0] fpat(input int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] hpat(input int i);
        return 8'(i * 53 + 7);
    endfunction

    task automatic async_phase(input int wpct, input int rpct);
        int issued = 0, popped = 0;
        fork
            begin
                while (issued < NWORDS) begin
                    @(negedge wclk);
                    if (!full_n) full_seen = 1;
                    if (full_n && $urandom_range(99) < wpct) begin
                        wen_n = 1'b0;
                        din = 8'($urandom_range(255));
                        q.push_back(din);
                        issued++;
                    end else begin
                        wen_n = 1'b1;
                        din = 8'($urandom_range(255));
                    end
                end
                @(negedge wclk);
                wen_n = 1'b1;
            end
            begin
                bit pending = 0;
                while (popped < NWORDS) begin
                    @(negedge rclk);
                    if (pending) begin
                        chk("R8 order", dout, q.pop_front());
                        popped++;
                    end
                    if (popped < NWORDS && $urandom_range(99) < rpct) ren_n = 1'b0;
                    else ren_n = 1'b1;
                    pending = (ren_n == 1'b0) && (empty_n == 1'b1);
                end
                ren_n = 1'b1;
            end
        join
    endtask

    initial begin
        repeat (3) @(negedge wclk);
        chk("R1 empty_n in reset", empty_n, 0);
        chk("R1 full_n in reset", full_n, 1);
        chk("R1 dout in reset", dout, 8'h00);
        rst_n = 1'b1;
        cyc();
        chk("R1 empty_n after reset", empty_n, 0);
        chk("R1 full_n after reset", full_n, 1);
        chk("R9 dout_vld driven", dout_vld, 1);

        // first-word latency, R6
        wen_n = 1'b0; din = 8'hA5;
        cyc();
        wen_n = 1'b1; din = 8'h3C;
        chk("R6 empty_n after edge n", empty_n, 0);
        cyc();
        chk("R6 empty_n after edge n+1", empty_n, 0);
        cyc();
        chk("R6 empty_n after edge n+2", empty_n, 1);
        ren_n = 1'b0;
        cyc();
        chk("R4 first word", dout, 8'hA5);
        chk("R6 empty_n after last read", empty_n, 0);
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R4 read on empty ignored", dout, 8'hA5);
        end
        ren_n = 1'b1;

        // fill, R3
        for (int i = 0; i < DEPTH; i++) begin
            wen_n = 1'b0; din = fpat(i);
            cyc();
            chk("R3 full_n during fill", full_n, (i == DEPTH - 1) ? 0 : 1);
        end
        for (int i = 0; i < 3; i++) begin
            din = 8'hEE;
            cyc();
            chk("R3 full_n stays low", full_n, 0);
        end
        wen_n = 1'b1;
        cyc();

        // full recovery, R7
        ren_n = 1'b0;
        cyc();
        ren_n = 1'b1;
        chk("R4 oldest word out", dout, fpat(0));
        chk("R7 full_n after edge m", full_n, 0);
        cyc();
        chk("R7 full_n after edge m+1", full_n, 0);
        cyc();
        chk("R7 full_n after edge m+2", full_n, 1);

        // drain, R3 R6
        ren_n = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            cyc();
            chk("R3 stored byte order", dout, fpat(k));
            chk("R6 empty_n during drain", empty_n, (k == DEPTH - 1) ? 0 : 1);
        end
        for (int i = 0; i < 2; i++) begin
            cyc();
            chk("R3 dropped writes absent", dout, fpat(DEPTH - 1));
        end
        ren_n = 1'b1;

        // overlapped traffic, R10
        for (int i = 0; i < 8; i++) begin
            wen_n = 1'b0; din = hpat(i);
            cyc();
        end
        wen_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            din = 8'(8'h90 + i);
            cyc();
        end
        for (int j = 0; j < 6; j++) begin
            wen_n = 1'b0; ren_n = 1'b0; din = hpat(8 + j);
            cyc();
            chk("R10 read side data", dout, hpat(j));
            chk("R10 empty_n steady", empty_n, 1);
            chk("R10 full_n steady", full_n, 1);
        end
        wen_n = 1'b1; ren_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R5 dout holds", dout, hpat(5));
        end
        ren_n = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cyc();
            chk("R10 remaining data", dout, hpat(6 + k));
            chk("R2 no extra bytes", empty_n, (k == 7) ? 0 : 1);
        end
        ren_n = 1'b1;

        // output gate, R9
        oe_n = 1'b1;
        #1;
        chk("R9 dout gated", dout, 8'h00);
        chk("R9 dout_vld low", dout_vld, 0);
        oe_n = 1'b0;
        #1;
        chk("R9 dout restored", dout, hpat(13));
        chk("R9 dout_vld high", dout_vld, 1);

        // unrelated clocks, R8
        cyc();
        shared = 1'b0;
        repeat (4) cyc();
        async_phase(80, 60);
        chk("R3 full boundary reached", full_seen, 1);
        async_phase(30, 90);
        repeat (6) @(negedge rclk);
        chk("R8 model drained", q.size(), 0);
        chk("R6 empty at end", empty_n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule